// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block runs one DMA channel job at a time from a control table kept in ordinary memory. A job starts on a one-cycle start strobe that names the table base, a channel number and which half of the table to use. The engine finds the 16-byte entry for that channel and fetches three words from it: the packed control word, the source end pointer and the destination end pointer. It then copies data items through a single request/grant memory port, one read followed by one write per item. It stores the updated control word back into the table.

Item addresses are counted backwards from the two end pointers. Because of this, a job that pauses at an arbitration boundary can resume on the next start from the count that was written back. The engine reports its position as a 4-bit state code. It raises a one-cycle done flag when a job finishes. In ping-pong mode it also reports that the next job belongs in the other half of the table.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset the state code is 0 (idle), there is no memory request, done_o is low and half_o is 0.
- R2: A start in idle fetches from entry = base + 16*(32*alt + chan). It reads the control word at entry+8 (state 1), then the source end pointer at entry+0 (state 2), then the destination end pointer at entry+4 (state 3).
- R3: Control word bits [2:0] select the mode: 1 basic, 2 auto-request, 3 ping-pong. Mode 0 (stop) and modes 4 to 7 move no data and write nothing back; the engine passes from state 1 straight to state 9 (done).
- R4: Bits [13:4] hold N-1 for N items. Item i (counting from 0) reads from src_end - (N-1-i)*inc and writes to dst_end - (N-1-i)*inc, each side using its own increment. The source increment is in bits [27:26] and the destination increment in bits [31:30]. The increment codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 = no increment, which means the end pointer every time.
- R5: The source size is in bits [25:24] and the destination size in bits [29:28]: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit. Each access drives that code on mem_size_o, with code 2 for table accesses. The write data is the read data zero-extended from the source size.
- R6: Bits [17:14] = n (0..9) set a group of 2^n items. In basic and ping-pong mode, when a group ends with items still remaining, the engine writes the control word back with the count set to the remaining items minus 1 and the mode unchanged. It then returns to idle without done, and the next start resumes the job.
- R7: Auto-request mode, and group codes 10 to 15, never stop at a group boundary: the whole job completes on one start.
- R8: On completion the engine writes the control word back with bits [2:0] = 0, bits [13:4] = 0x3FF and all other bits unchanged. It then holds state 9 with done_o high for exactly one cycle, and returns to idle.
- R9: After a ping-pong job completes, half_o is the opposite of the alt value used. In every other case half_o equals the alt value of the last start.
- R10: A request holds its address, direction, size and write data until granted, and read data is taken in the grant cycle. Data reads show state 4, data writes state 5 and the write-back state 7. Codes 6 and 8 are never shown.
- R11: A start while the engine is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | AW | Table base address, 1024-byte aligned |
| chan_i | input | CH_W | Channel number |
| alt_i | input | 1 | 0 primary half, 1 alternate half |
| start_i | input | 1 | Start strobe, sampled in idle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 32 | Write data, right aligned |
| mem_gnt_i | input | 1 | Grant, completes the access |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| state_o | output | 4 | Current state code |
| done_o | output | 1 | One-cycle job-complete flag |
| half_o | output | 1 | Table half for the next job |

## Verification
The bench covers several corner cases, each of which would show up as a distinct visible error:

- **Resume after a pause.** A group size smaller than the job forces pause-and-resume. A design that lost the remaining count, or restarted from the first item, would need the wrong number of starts and would leave the wrong count in the table.
- **Full count and largest group.** The full 1024-item count with a 512-item group checks that the count field and the group counter do not wrap early.
- **No-increment sides.** No-increment sources and destinations check that the shifted offset is dropped. Otherwise the engine would walk outside the end pointer.
- **Mixed widths.** Mixed source and destination widths check zero extension and byte counts.
- **Ping-pong half swap.** Ping-pong jobs run on both halves to check the half swap.
- **Stopped and unsupported modes.** These must finish with a single table read and no writes.
- **Stray start mid-job.** A start pulse during a job must not disturb another channel's entry.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_CTRL = 4'd1,
    ST_RD_SRC  = 4'd2,
    ST_RD_DST  = 4'd3,
    ST_RD_DATA = 4'd4,
    ST_WR_DATA = 4'd5,
    ST_WAIT    = 4'd6,
    ST_WR_CTRL = 4'd7,
    ST_STALL   = 4'd8,
    ST_DONE    = 4'd9
  } dma_state_e;

  typedef enum logic [2:0] {
    MODE_STOP  = 3'd0,
    MODE_BASIC = 3'd1,
    MODE_AUTO  = 3'd2,
    MODE_PING  = 3'd3
  } dma_mode_e;

  typedef struct packed {
    logic [1:0] dst_inc;
    logic [1:0] dst_size;
    logic [1:0] src_inc;
    logic [1:0] src_size;
    logic [5:0] rsvd;
    logic [3:0] grp;
    logic [9:0] count;
    logic       burst;
    logic [2:0] mode;
  } ctrl_word_t;

  localparam int CNT_W = 10;
  localparam int GRP_W = 4;

  function automatic logic [31:0] trim_data(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'b0, d[7:0]};
      2'd1:    return {16'b0, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic mode_runs(input logic [2:0] m);
    return (m == MODE_BASIC) || (m == MODE_AUTO) || (m == MODE_PING);
  endfunction

endpackage

// File: rtl/dma_item_addr.sv
module dma_item_addr #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] rem_i,
  input  logic [1:0]    inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] offset;

  // code 3 = fixed address, otherwise step is 1 << code bytes
  assign offset = (inc_i == 2'd3) ? '0 : (AW'(rem_i) << inc_i);
  assign addr_o = end_i - offset;
endmodule

// File: rtl/dma_group_ctr.sv
module dma_group_ctr #(
  parameter int GW_CODE = 4,
  parameter int MAX_LOG = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [GW_CODE-1:0] grp_i,
  output logic               last_o
);
  localparam int GW = MAX_LOG + 2;
  localparam logic [GW_CODE-1:0] MAX_CODE = GW_CODE'(MAX_LOG);

  logic [GW-1:0] cnt_q;
  logic [GW-1:0] grp_size;
  logic          bounded;

  assign bounded  = (grp_i <= MAX_CODE);
  assign grp_size = bounded ? (GW'(1) << grp_i) : '0;
  assign last_o   = bounded && ((cnt_q + GW'(1)) == grp_size);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && last_o)   cnt_q <= '0;
    else if (inc_i)             cnt_q <= cnt_q + GW'(1);
  end

  // R6: group counter never runs past its group
  assert_grp_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && bounded) |-> (cnt_q < grp_size));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_CH  = 32,
  parameter int MAX_LOG = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             base_i,
  input  logic [$clog2(NUM_CH)-1:0] chan_i,
  input  logic                      alt_i,
  input  logic                      start_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [1:0]                mem_size_o,
  output logic [31:0]               mem_wdata_o,
  input  logic                      mem_gnt_i,
  input  logic [31:0]               mem_rdata_i,
  output logic [3:0]                state_o,
  output logic                      done_o,
  output logic                      half_o
);
  localparam int DESC_BYTES = 16;
  localparam logic [AW-1:0] OFS_SRC  = AW'(0);
  localparam logic [AW-1:0] OFS_DST  = AW'(4);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8);

  dma_state_e    state_q;
  ctrl_word_t    ctrl_q;
  logic [AW-1:0] entry_q, src_end_q, dst_end_q;
  logic [31:0]   data_q;
  logic          alt_q, half_q, fin_q;
  logic          grp_last;
  logic          grp_clr, grp_inc;

  logic [AW-1:0] side_end  [2];
  logic [1:0]    side_inc  [2];
  logic [AW-1:0] side_addr [2];

  assign side_end[0] = src_end_q;
  assign side_end[1] = dst_end_q;
  assign side_inc[0] = ctrl_q.src_inc;
  assign side_inc[1] = ctrl_q.dst_inc;

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_item_addr #(.AW(AW), .CW(CNT_W)) i_addr (
      .end_i  (side_end[s]),
      .rem_i  (ctrl_q.count),
      .inc_i  (side_inc[s]),
      .addr_o (side_addr[s])
    );
  end

  assign grp_clr = (state_q == ST_RD_DST) && mem_gnt_i;
  assign grp_inc = (state_q == ST_WR_DATA) && mem_gnt_i;

  dma_group_ctr #(.GW_CODE(GRP_W), .MAX_LOG(MAX_LOG)) i_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (grp_clr),
    .inc_i  (grp_inc),
    .grp_i  (ctrl_q.grp),
    .last_o (grp_last)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = entry_q + OFS_CTRL;
    mem_size_o  = 2'd2;
    mem_wdata_o = ctrl_q;
    case (state_q)
      ST_RD_CTRL: mem_req_o = 1'b1;
      ST_RD_SRC:  begin mem_req_o = 1'b1; mem_addr_o = entry_q + OFS_SRC; end
      ST_RD_DST:  begin mem_req_o = 1'b1; mem_addr_o = entry_q + OFS_DST; end
      ST_RD_DATA: begin
        mem_req_o  = 1'b1;
        mem_addr_o = side_addr[0];
        mem_size_o = ctrl_q.src_size;
      end
      ST_WR_DATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = side_addr[1];
        mem_size_o  = ctrl_q.dst_size;
        mem_wdata_o = data_q;
      end
      ST_WR_CTRL: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ctrl_q    <= '0;
      entry_q   <= '0;
      src_end_q <= '0;
      dst_end_q <= '0;
      data_q    <= '0;
      alt_q     <= 1'b0;
      half_q    <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          entry_q <= base_i + (AW'(alt_i) * AW'(NUM_CH) + AW'(chan_i)) * AW'(DESC_BYTES);
          alt_q   <= alt_i;
          half_q  <= alt_i;
          state_q <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (mem_gnt_i) begin
          ctrl_q  <= mem_rdata_i;
          state_q <= mode_runs(mem_rdata_i[2:0]) ? ST_RD_SRC : ST_DONE;
        end
        ST_RD_SRC: if (mem_gnt_i) begin
          src_end_q <= mem_rdata_i;
          state_q   <= ST_RD_DST;
        end
        ST_RD_DST: if (mem_gnt_i) begin
          dst_end_q <= mem_rdata_i;
          state_q   <= ST_RD_DATA;
        end
        ST_RD_DATA: if (mem_gnt_i) begin
          data_q  <= trim_data(mem_rdata_i, ctrl_q.src_size);
          state_q <= ST_WR_DATA;
        end
        ST_WR_DATA: if (mem_gnt_i) begin
          if (ctrl_q.count == '0) begin
            ctrl_q.mode  <= MODE_STOP;
            ctrl_q.count <= '1;
            fin_q        <= 1'b1;
            state_q      <= ST_WR_CTRL;
            if (ctrl_q.mode == MODE_PING) half_q <= ~alt_q;
          end else begin
            ctrl_q.count <= ctrl_q.count - 1'b1;
            if (grp_last && (ctrl_q.mode != MODE_AUTO)) begin
              fin_q   <= 1'b0;
              state_q <= ST_WR_CTRL;
            end else begin
              state_q <= ST_RD_DATA;
            end
          end
        end
        ST_WR_CTRL: if (mem_gnt_i) state_q <= fin_q ? ST_DONE : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign done_o  = (state_q == ST_DONE);
  assign half_o  = half_q;

  // R10: request is held unchanged until granted
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_size_o) && $stable(mem_wdata_o)));

  // R3: a non-moving mode goes from control read straight to done
  assert_stop_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_CTRL && mem_gnt_i && !mode_runs(mem_rdata_i[2:0])) |=> (state_o == ST_DONE));

  // R8: done lasts one cycle and is followed by idle
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && state_o == ST_IDLE));

  // R8: final write-back carries stop mode and all-ones count
  assert_final_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_CTRL && fin_q) |-> (mem_wdata_o[2:0] == 3'd0 && mem_wdata_o[13:4] == 10'h3ff));

  // R11: entry address frozen while busy
  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(entry_q));
endmodule

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE    = 32'h0000_0400;
  localparam logic [31:0] SRC_END = 32'h0000_0C00;
  localparam logic [31:0] DST_END = 32'h0000_1400;

  typedef struct packed {
    logic [2:0] mode; logic [9:0] cnt; logic [3:0] grp;
    logic [1:0] ssz; logic [1:0] sinc; logic [1:0] dsz; logic [1:0] dinc;
    logic [4:0] ch; logic alt; logic [1:0] lat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 10'd7,    4'd10, 2'd2, 2'd2, 2'd2, 2'd2, 5'd0,  1'b0, 2'd0},
    '{3'd1, 10'd9,    4'd2,  2'd0, 2'd0, 2'd0, 2'd0, 5'd3,  1'b0, 2'd1},
    '{3'd2, 10'd9,    4'd1,  2'd1, 2'd1, 2'd1, 2'd1, 5'd31, 1'b1, 2'd0},
    '{3'd3, 10'd4,    4'd10, 2'd2, 2'd2, 2'd0, 2'd0, 5'd7,  1'b0, 2'd2},
    '{3'd3, 10'd3,    4'd0,  2'd0, 2'd3, 2'd2, 2'd2, 5'd7,  1'b1, 2'd0},
    '{3'd1, 10'd5,    4'd3,  2'd1, 2'd2, 2'd1, 2'd3, 5'd1,  1'b1, 2'd1},
    '{3'd2, 10'd40,   4'd15, 2'd2, 2'd2, 2'd2, 2'd2, 5'd16, 1'b0, 2'd1},
    '{3'd1, 10'd1023, 4'd9,  2'd0, 2'd3, 2'd0, 2'd3, 5'd2,  1'b1, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] base = BASE;
  logic [4:0]  chan = '0;
  logic alt = 1'b0, start = 1'b0;
  logic mem_req, mem_we, mem_gnt = 1'b0, done, half;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0]  mem_size;
  logic [3:0]  state;

  logic [7:0] mem [0:8191];
  logic [7:0] exp_mem [0:8191];
  int lat = 0, wcnt = 0, rd_n = 0, wr_data_n = 0, wr_tbl_n = 0, done_run = 0, max_run = 0;
  logic [31:0] rd_log [4];
  logic [15:0] seen = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_engine i_dma_desc_engine (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .chan_i(chan), .alt_i(alt), .start_i(start),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .state_o(state), .done_o(done), .half_o(half)
  );

  // memory model and monitor
  always @(negedge clk) begin
    mem_gnt = 1'b0;
    if (!rst_n) wcnt = 0;
    else begin
      seen[state] = 1'b1;
      if (done) done_run++; else done_run = 0;
      if (done_run > max_run) max_run = done_run;
      if (mem_req) begin
        if (wcnt >= lat) begin
          int a;
          wcnt = 0;
          mem_gnt = 1'b1;
          a = int'(mem_addr[12:0]);
          if (mem_we) begin
            for (int k = 0; k < (1 << mem_size); k++) mem[(a + k) & 8191] = mem_wdata[8*k +: 8];
            if (mem_addr >= 32'h800) wr_data_n++; else wr_tbl_n++;
          end else begin
            mem_rdata = {mem[(a+3)&8191], mem[(a+2)&8191], mem[(a+1)&8191], mem[a]};
            if (rd_n < 4) rd_log[rd_n] = mem_addr;
            rd_n++;
          end
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] entry_of(input int ch, input bit a);
    return BASE + 32'(16 * (32 * int'(a) + ch));
  endfunction

  task automatic put_word(input logic [31:0] ad, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[(int'(ad) + k) & 8191] = w[8*k +: 8];
  endtask

  function automatic logic [31:0] get_word(input logic [31:0] ad);
    return {mem[(int'(ad)+3)&8191], mem[(int'(ad)+2)&8191], mem[(int'(ad)+1)&8191], mem[int'(ad)&8191]};
  endfunction

  task automatic do_start(input int ch, input bit a);
    chan = 5'(ch); alt = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit got_done);
    got_done = 1'b0;
    while (state != 4'd0) begin
      if (done) got_done = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=%0h expected=%0h", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit gd;
    for (int k = 0; k < 8192; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 4'd0, "R1", "reset state", 32'(state), 0);
    chk(!mem_req, "R1", "reset req", 32'(mem_req), 0);
    chk(!done && !half, "R1", "reset done/half", {done, half}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == 4'd0 && !mem_req, "R1", "idle after release", 32'(state), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] cw, ent;
      int n, g, exp_starts, starts, bad;
      t = VECS[v];
      lat = int'(t.lat);
      ent = entry_of(int'(t.ch), t.alt);
      cw = {t.dinc, t.dsz, t.sinc, t.ssz, 6'b0, t.grp, t.cnt, 1'b0, t.mode};
      for (int k = 32'h800; k < 32'h1000; k++) mem[k] = 8'((k * 13 + v * 7 + 1) & 255);
      for (int k = 32'h1000; k < 32'h1800; k++) mem[k] = 8'hEE;
      put_word(ent, SRC_END); put_word(ent + 4, DST_END); put_word(ent + 8, cw);
      for (int k = 0; k < 8192; k++) exp_mem[k] = mem[k];
      n = int'(t.cnt) + 1;
      for (int i = 0; i < n; i++) begin
        int rem, sa, da;
        logic [31:0] d;
        rem = n - 1 - i;
        sa = int'(SRC_END) - ((t.sinc == 2'd3) ? 0 : (rem << t.sinc));
        da = int'(DST_END) - ((t.dinc == 2'd3) ? 0 : (rem << t.dinc));
        d = {exp_mem[sa+3], exp_mem[sa+2], exp_mem[sa+1], exp_mem[sa]};
        if (t.ssz == 2'd0) d = d & 32'hFF; else if (t.ssz == 2'd1) d = d & 32'hFFFF;
        for (int k = 0; k < (1 << t.dsz); k++) exp_mem[da + k] = d[8*k +: 8];
      end
      g = 1 << t.grp;
      exp_starts = (t.mode == 3'd2 || t.grp >= 4'd10) ? 1 : (n + g - 1) / g;
      starts = 0; max_run = 0; rd_n = 0;
      do begin
        do_start(int'(t.ch), t.alt);
        wait_end(gd);
        starts++;
        if (starts == 1) begin
          // R2 fetch order: ctrl, src end, dst end
          chk(rd_log[0] == ent + 8 && rd_log[1] == ent && rd_log[2] == ent + 4, "R2",
              "fetch order", rd_log[0], ent + 8);
          if (!gd) begin
            logic [31:0] pw;
            pw = get_word(ent + 8);
            chk(pw[13:4] == 10'(int'(t.cnt) - g) && pw[2:0] == t.mode, "R6", "paused ctrl word",
                pw, {cw[31:14], 10'(int'(t.cnt) - g), cw[3:0]});
          end
        end
      end while (!gd && starts < 2000);
      chk(starts == exp_starts, (t.mode == 3'd2 || t.grp >= 4'd10) ? "R7" : "R6",
          "start count", starts, exp_starts);
      bad = 0;
      for (int k = 32'h1000; k < 32'h1800; k++) if (mem[k] !== exp_mem[k]) bad++;
      chk(bad == 0, (t.ssz != t.dsz) ? "R5" : "R4", "dest bytes mismatching", bad, 0);
      chk(get_word(ent + 8) == ((cw & ~32'h3FF7) | 32'h3FF0), "R8", "final ctrl word",
          get_word(ent + 8), (cw & ~32'h3FF7) | 32'h3FF0);
      chk(max_run == 1, "R8", "done pulse width", max_run, 1);
      chk(half == (t.alt ^ (t.mode == 3'd3)), "R9", "half after job", 32'(half),
          32'(t.alt ^ (t.mode == 3'd3)));
    end

    // R10 state codes seen during data movement, reserved codes never shown
    chk(seen[4] && seen[5] && seen[7], "R10", "data states seen", 32'(seen), 32'h2BF);
    chk(!seen[6] && !seen[8], "R10", "reserved states absent", 32'(seen), 0);

    // R3 stop mode and an unsupported mode
    for (int m = 0; m < 2; m++) begin
      logic [31:0] cw, ent;
      cw = {8'hAA, 6'b0, 4'd2, 10'd5, 1'b0, (m == 0) ? 3'd0 : 3'd6};
      ent = entry_of(9, 1'b0);
      put_word(ent + 8, cw);
      rd_n = 0; wr_data_n = 0; wr_tbl_n = 0; lat = 0;
      do_start(9, 1'b0);
      wait_end(gd);
      chk(gd, "R3", "done without transfer", 32'(gd), 1);
      chk(rd_n == 1 && wr_data_n == 0 && wr_tbl_n == 0, "R3", "accesses (reads)", rd_n, 1);
      chk(get_word(ent + 8) == cw, "R3", "ctrl untouched", get_word(ent + 8), cw);
    end

    // R11 start while busy is ignored
    begin
      logic [31:0] e4, e5, c5;
      e4 = entry_of(4, 1'b0); e5 = entry_of(5, 1'b0);
      c5 = {2'd2, 2'd2, 2'd2, 2'd2, 6'b0, 4'd10, 10'd3, 1'b0, 3'd1};
      put_word(e4, SRC_END); put_word(e4 + 4, DST_END);
      put_word(e4 + 8, {2'd2, 2'd2, 2'd2, 2'd2, 6'b0, 4'd10, 10'd20, 1'b0, 3'd1});
      put_word(e5, SRC_END); put_word(e5 + 4, DST_END); put_word(e5 + 8, c5);
      lat = 1; rd_n = 0;
      do_start(4, 1'b0);
      repeat (6) @(negedge clk);
      do_start(5, 1'b0);
      wait_end(gd);
      chk(gd, "R11", "first job completes", 32'(gd), 1);
      chk(get_word(e5 + 8) == c5, "R11", "other entry untouched", get_word(e5 + 8), c5);
      chk(rd_log[0] == e4 + 8, "R11", "only first entry fetched", rd_log[0], e4 + 8);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule